// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block holds the power-management state of one processor core and moves it between six states: run, auto-halt, stop-grant, snoop service, sleep and deep sleep. Each cycle, on the rising clock edge, it samples a set of active-high request lines. These lines come from the core (halt retired), from the platform (stop-clock, sleep, clock-stopped) and from the bus and interrupt logic (snoop hit, bus-init, init, system-management interrupt, non-maskable and maskable interrupts, cache flush, core reset). From them it picks one next state.

The block drives the encoded state, a clock enable for the core's internal clocks, a one-cycle strobe that tells the cache to service a flush, and a one-cycle indication that the machine has gone back to a state it left earlier. A one-bit clock-stop enable, written through a 32-bit configuration word, decides whether the clocks really stop in the three gated states. All pins are plain level or strobe signals. No stream interface is present, so there is no back-pressure.

Every output comes from a register. A change caused by inputs sampled at edge N is visible in the cycle after edge N. The active-low `rst_n` is a power-on reset for the block itself. The core-reset request is one of the sampled inputs.

Top module: `lp_state_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 and `clk_en_o` is 1. `flush_ack_o` and `resume_o` are 0, and the clock-stop enable is 1. State codes: run=0, auto-halt=1, stop-grant=2, snoop=3, sleep=4, deep sleep=5.
- R2: In run, stop-clock high moves to stop-grant. Otherwise, halt-retired moves to auto-halt.
- R3: In auto-halt, any of system-management interrupt, bus-init, init, non-maskable or maskable interrupt moves to run. This takes priority over stop-clock and flush.
- R4: In auto-halt, a flush request with no wake and no stop-clock makes `flush_ack_o` high for one cycle, and the state stays auto-halt. In every other state a flush request gives no strobe and does not change the state.
- R5: Stop-clock in auto-halt moves to stop-grant. In stop-grant, with no bus-init, a low stop-clock returns to the state stop-grant was entered from (run or auto-halt).
- R6: In stop-grant, bus-init takes priority over every other request except core reset. The next state is stop-grant if stop-clock is high and run if it is low.
- R7: Core reset has the highest priority. In stop-grant the state stays stop-grant, and the next release of stop-clock goes to run. In any other state core reset forces run.
- R8: In stop-grant with stop-clock held, a snoop hit moves to snoop. The state stays snoop for exactly 4 cycles, ignoring every request except core reset, and then returns to stop-grant.
- R9: In stop-grant, sleep high with no snoop moves to sleep. In sleep, sleep low returns to stop-grant; otherwise clock-stopped high moves to deep sleep. In deep sleep, clock-stopped low returns to sleep.
- R10: `clk_en_o` is 0 exactly when the state is stop-grant, sleep or deep sleep and the clock-stop enable is 1. A configuration write loads the enable from bit 26 of `cfg_wdata_i`. Both effects show in the cycle after the sampling edge.
- R11: `resume_o` is high for the one cycle after a return from stop-grant to auto-halt or from snoop to stop-grant, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_retired_i | input | 1 | Halt instruction retired |
| stop_clk_i | input | 1 | Stop-clock request (level) |
| sleep_req_i | input | 1 | Sleep request (level) |
| snoop_hit_i | input | 1 | Bus snoop detected |
| bus_init_i | input | 1 | Bus initialisation |
| init_i | input | 1 | Core init request |
| smi_i | input | 1 | System-management interrupt |
| nmi_i | input | 1 | Non-maskable interrupt line |
| intr_i | input | 1 | Maskable interrupt line |
| flush_req_i | input | 1 | Cache flush request |
| core_rst_i | input | 1 | Core reset request |
| clk_stopped_i | input | 1 | External clock has stopped (level) |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration word; bit 26 is the clock-stop enable |
| state_o | output | 3 | Current state code |
| clk_en_o | output | 1 | Internal clock enable |
| flush_ack_o | output | 1 | Flush-service strobe |
| resume_o | output | 1 | Return-to-previous-state indication |

## Verification
The collisions that matter are between requests that pull the same state in different directions in one cycle:
- A flush arriving together with a wake or a stop-clock in auto-halt.
- A bus-init arriving in the very cycle stop-clock is released.
- A snoop and a sleep request arriving together in stop-grant.
- A core reset arriving together with any of the above.

Directed steps raise each such pair on the same edge. Long random runs with dense pulse inputs and slowly toggling level inputs make these collisions happen many more times. In every cycle, the state, flush strobe, return indication and clock enable are compared with a priority-ordered model of the requirements.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_AHALT  = 3'd1,
    PS_SGRANT = 3'd2,
    PS_SNOOP  = 3'd3,
    PS_SLEEP  = 3'd4,
    PS_DEEP   = 3'd5
  } pstate_e;

  typedef struct packed {
    logic halt;
    logic stop_clk;
    logic sleep;
    logic snoop;
    logic binit;
    logic init;
    logic smi;
    logic nmi;
    logic intr;
    logic flush;
    logic core_rst;
    logic clk_stopped;
  } req_s;

  function automatic logic is_gated(pstate_e s);
    return (s == PS_SGRANT) || (s == PS_SLEEP) || (s == PS_DEEP);
  endfunction

endpackage

// File: rtl/lp_cfg_reg.sv
module lp_cfg_reg #(
  parameter int CFG_W     = 32,
  parameter int STOP_BIT  = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             gate_en_o,
  output logic             gate_en_nxt_o
);
  logic gate_q;
  logic unused_bits;

  assign unused_bits   = ^wdata_i;
  assign gate_en_nxt_o = we_i ? wdata_i[STOP_BIT] : gate_q;
  assign gate_en_o     = gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate_en_nxt_o;
  end

  assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(gate_q));
  assert_gate_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> gate_q == $past(wdata_i[STOP_BIT]));
endmodule

// File: rtl/lp_snoop_timer.sv
module lp_snoop_timer #(
  parameter int SNOOP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic done_o
);
  localparam int CW = $clog2(SNOOP_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = active_i && (cnt_q == CW'(SNOOP_CYC - 1));

  assert_snoop_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> cnt_q < CW'(SNOOP_CYC));
endmodule

// File: rtl/lp_next_state.sv
module lp_next_state
  import lp_pkg::*;
(
  input  pstate_e state_i,
  input  pstate_e origin_i,
  input  req_s    req_i,
  input  logic    snoop_done_i,
  output pstate_e nxt_o,
  output pstate_e nxt_origin_o,
  output logic    flush_svc_o,
  output logic    resume_o
);
  logic wake;
  assign wake = req_i.smi | req_i.binit | req_i.init | req_i.nmi | req_i.intr;

  always_comb begin
    nxt_o        = state_i;
    nxt_origin_o = origin_i;
    flush_svc_o  = 1'b0;
    resume_o     = 1'b0;
    if (req_i.core_rst) begin
      // stop-grant survives a core reset, but forgets an auto-halt origin
      if (state_i == PS_SGRANT) nxt_origin_o = PS_RUN;
      else                      nxt_o        = PS_RUN;
    end else begin
      unique case (state_i)
        PS_RUN: begin
          if (req_i.stop_clk) begin
            nxt_o        = PS_SGRANT;
            nxt_origin_o = PS_RUN;
          end else if (req_i.halt) begin
            nxt_o = PS_AHALT;
          end
        end
        PS_AHALT: begin
          if (wake) begin
            nxt_o = PS_RUN;
          end else if (req_i.stop_clk) begin
            nxt_o        = PS_SGRANT;
            nxt_origin_o = PS_AHALT;
          end else begin
            flush_svc_o = req_i.flush;
          end
        end
        PS_SGRANT: begin
          if (req_i.binit) begin
            if (!req_i.stop_clk) nxt_o = PS_RUN;
          end else if (!req_i.stop_clk) begin
            nxt_o    = origin_i;
            resume_o = (origin_i == PS_AHALT);
          end else if (req_i.snoop) begin
            nxt_o = PS_SNOOP;
          end else if (req_i.sleep) begin
            nxt_o = PS_SLEEP;
          end
        end
        PS_SNOOP: begin
          if (snoop_done_i) begin
            nxt_o    = PS_SGRANT;
            resume_o = 1'b1;
          end
        end
        PS_SLEEP: begin
          if (!req_i.sleep)          nxt_o = PS_SGRANT;
          else if (req_i.clk_stopped) nxt_o = PS_DEEP;
        end
        PS_DEEP: begin
          if (!req_i.clk_stopped) nxt_o = PS_SLEEP;
        end
        default: nxt_o = PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int STOP_BIT  = 26,
  parameter int SNOOP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_retired_i,
  input  logic             stop_clk_i,
  input  logic             sleep_req_i,
  input  logic             snoop_hit_i,
  input  logic             bus_init_i,
  input  logic             init_i,
  input  logic             smi_i,
  input  logic             nmi_i,
  input  logic             intr_i,
  input  logic             flush_req_i,
  input  logic             core_rst_i,
  input  logic             clk_stopped_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [2:0]       state_o,
  output logic             clk_en_o,
  output logic             flush_ack_o,
  output logic             resume_o
);
  req_s    req;
  pstate_e state_q, origin_q, nxt, nxt_origin;
  logic    flush_svc, resume_evt, snoop_done;
  logic    gate_en, gate_en_nxt;
  logic    clk_en_q, flush_q, resume_q;

  assign req = '{halt: halt_retired_i, stop_clk: stop_clk_i, sleep: sleep_req_i,
                 snoop: snoop_hit_i, binit: bus_init_i, init: init_i, smi: smi_i,
                 nmi: nmi_i, intr: intr_i, flush: flush_req_i, core_rst: core_rst_i,
                 clk_stopped: clk_stopped_i};

  lp_cfg_reg #(.CFG_W(CFG_W), .STOP_BIT(STOP_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .gate_en_o(gate_en), .gate_en_nxt_o(gate_en_nxt));

  lp_snoop_timer #(.SNOOP_CYC(SNOOP_CYC)) u_snoop (
    .clk(clk), .rst_n(rst_n), .active_i(state_q == PS_SNOOP), .done_o(snoop_done));

  lp_next_state u_nxt (
    .state_i(state_q), .origin_i(origin_q), .req_i(req), .snoop_done_i(snoop_done),
    .nxt_o(nxt), .nxt_origin_o(nxt_origin), .flush_svc_o(flush_svc),
    .resume_o(resume_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_RUN;
      origin_q <= PS_RUN;
      clk_en_q <= 1'b1;
      flush_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= nxt;
      origin_q <= nxt_origin;
      clk_en_q <= !(gate_en_nxt && is_gated(nxt));
      flush_q  <= flush_svc;
      resume_q <= resume_evt;
    end
  end

  assign state_o     = state_q;
  assign clk_en_o    = clk_en_q;
  assign flush_ack_o = flush_q;
  assign resume_o    = resume_q;

  assert_flush_in_ahalt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> state_q == PS_AHALT);
  assert_rst_keeps_sgrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_i && state_q == PS_SGRANT) |=> state_q == PS_SGRANT);
  assert_rst_to_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_i && state_q != PS_SGRANT) |=> state_q == PS_RUN);
  assert_deep_via_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_SLEEP && state_q != PS_DEEP) |=> state_q != PS_DEEP);
  assert_clk_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_q == !(gate_en && is_gated(state_q)));
  assert_resume_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> (state_q == PS_AHALT || state_q == PS_SGRANT));
  assert_sgrant_binit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SGRANT && bus_init_i && !core_rst_i && stop_clk_i) |=> state_q == PS_SGRANT);
endmodule

// File: tb/lp_state_ctrl_test.sv
module lp_state_ctrl_test;
  localparam int CLK_P     = 10;
  localparam int SNOOP_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 0, stop_clk = 0, sleep = 0, snoop = 0, binit = 0, init = 0;
  logic smi = 0, nmi = 0, intr = 0, flush = 0, core_rst = 0, clk_stopped = 0;
  logic cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0] state_o;
  logic clk_en_o, flush_ack_o, resume_o;

  int checks = 0, errors = 0;
  int m_st = 0, m_org = 0, m_cnt = 0;
  bit m_gate = 1, m_clken = 1, m_flush = 0, m_res = 0;
  string m_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  lp_state_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_retired_i(halt), .stop_clk_i(stop_clk),
    .sleep_req_i(sleep), .snoop_hit_i(snoop), .bus_init_i(binit), .init_i(init),
    .smi_i(smi), .nmi_i(nmi), .intr_i(intr), .flush_req_i(flush),
    .core_rst_i(core_rst), .clk_stopped_i(clk_stopped), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .state_o(state_o), .clk_en_o(clk_en_o),
    .flush_ack_o(flush_ack_o), .resume_o(resume_o));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit gated(int s);
    return s == 2 || s == 4 || s == 5;
  endfunction

  // expected next values from the requirements, priority order as stated
  task automatic model_step();
    int ns = m_st, no = m_org;
    bit fl = 0, rs = 0;
    if (core_rst) begin
      m_tag = "R7";
      if (m_st == 2) no = 0; else ns = 0;
    end else begin
      case (m_st)
        0: begin m_tag = "R2"; if (stop_clk) begin ns = 2; no = 0; end else if (halt) ns = 1; end
        1: if (smi | binit | init | nmi | intr) begin m_tag = "R3"; ns = 0; end
           else if (stop_clk) begin m_tag = "R5"; ns = 2; no = 1; end
           else begin m_tag = "R4"; fl = flush; end
        2: if (binit) begin m_tag = "R6"; if (!stop_clk) ns = 0; end
           else if (!stop_clk) begin m_tag = "R5"; ns = m_org; rs = (m_org == 1); end
           else if (snoop) begin m_tag = "R8"; ns = 3; end
           else begin m_tag = "R9"; if (sleep) ns = 4; end
        3: begin m_tag = "R8"; if (m_cnt == SNOOP_CYC-1) begin ns = 2; rs = 1; end end
        4: begin m_tag = "R9"; if (!sleep) ns = 2; else if (clk_stopped) ns = 5; end
        default: begin m_tag = "R9"; if (!clk_stopped) ns = 4; end
      endcase
    end
    m_cnt = (m_st == 3) ? m_cnt + 1 : 0;
    if (cfg_we) m_gate = cfg_wdata[26];
    m_st = ns; m_org = no; m_flush = fl; m_res = rs;
    m_clken = !(m_gate && gated(ns));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk); #1;
    chk(m_tag, "state", state_o, m_st);
    chk("R4", "flush_ack", flush_ack_o, m_flush);
    chk("R11", "resume", resume_o, m_res);
    chk("R10", "clk_en", clk_en_o, m_clken);
  endtask

  task automatic at_neg();
    @(negedge clk);
    halt = 0; snoop = 0; binit = 0; init = 0; smi = 0; nmi = 0; intr = 0;
    flush = 0; core_rst = 0; cfg_we = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset state", state_o, 0);
    chk("R1", "reset clk_en", clk_en_o, 1);
    chk("R1", "reset flush", flush_ack_o, 0);
    chk("R1", "reset resume", resume_o, 0);
    @(negedge clk); rst_n = 1;

    // run -> auto-halt, flush, stop-clock round trip, wake
    at_neg(); halt = 1; cyc();           chk("R2", "halt", state_o, 1);
    at_neg(); flush = 1; cyc();          chk("R4", "flush strobe", flush_ack_o, 1);
    chk("R4", "stays ahalt", state_o, 1);
    at_neg(); cyc();                     chk("R4", "strobe one cycle", flush_ack_o, 0);
    at_neg(); stop_clk = 1; flush = 1; cyc();
    chk("R5", "ahalt->sgrant", state_o, 2);
    chk("R4", "flush lost to stop", flush_ack_o, 0);
    chk("R10", "gated", clk_en_o, 0);
    at_neg(); stop_clk = 0; cyc();       chk("R5", "back to ahalt", state_o, 1);
    chk("R11", "resume pulse", resume_o, 1);
    at_neg(); intr = 1; flush = 1; stop_clk = 1; cyc();
    chk("R3", "wake wins", state_o, 0);
    chk("R4", "no flush on wake", flush_ack_o, 0);

    // stop-grant corner cases
    at_neg(); cyc();                     chk("R2", "run->sgrant", state_o, 2);
    at_neg(); flush = 1; cyc();          chk("R4", "flush ignored", flush_ack_o, 0);
    chk("R4", "sgrant kept", state_o, 2);
    at_neg(); core_rst = 1; cyc();       chk("R7", "reset keeps sgrant", state_o, 2);
    at_neg(); snoop = 1; sleep = 1; cyc();
    chk("R8", "snoop wins over sleep", state_o, 3);
    for (int i = 0; i < SNOOP_CYC - 1; i++) begin
      at_neg(); cyc(); chk("R8", "snoop held", state_o, 3);
    end
    at_neg(); cyc();                     chk("R8", "snoop done", state_o, 2);
    chk("R11", "snoop resume", resume_o, 1);
    at_neg(); cyc();                     chk("R9", "sgrant->sleep", state_o, 4);
    at_neg(); clk_stopped = 1; cyc();    chk("R9", "deep", state_o, 5);
    at_neg(); clk_stopped = 0; cyc();    chk("R9", "deep->sleep", state_o, 4);
    at_neg(); sleep = 0; cyc();          chk("R9", "sleep->sgrant", state_o, 2);
    at_neg(); binit = 1; cyc();          chk("R6", "binit held stop", state_o, 2);
    at_neg(); binit = 1; stop_clk = 0; cyc();
    chk("R6", "binit release", state_o, 0);
    chk("R11", "no resume to run", resume_o, 0);

    // halt origin lost by core reset in stop-grant
    at_neg(); halt = 1; cyc();
    at_neg(); stop_clk = 1; cyc();
    at_neg(); core_rst = 1; cyc();
    at_neg(); stop_clk = 0; cyc();       chk("R7", "release after reset", state_o, 0);

    // clock-stop enable cleared
    at_neg(); cfg_we = 1; cfg_wdata = 32'h0; stop_clk = 1; cyc();
    chk("R10", "no gating", clk_en_o, 1);
    at_neg(); cfg_we = 1; cfg_wdata = 32'h0400_0000; cyc();
    chk("R10", "gating back", clk_en_o, 0);
    at_neg(); stop_clk = 0; cyc();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      at_neg();
      if ($urandom_range(5) == 0) stop_clk = ~stop_clk;
      if ($urandom_range(4) == 0) sleep = ~sleep;
      if ($urandom_range(4) == 0) clk_stopped = ~clk_stopped;
      halt  = ($urandom_range(3) == 0);
      flush = ($urandom_range(3) == 0);
      snoop = ($urandom_range(4) == 0);
      binit = ($urandom_range(15) == 0);
      init  = ($urandom_range(15) == 0);
      smi   = ($urandom_range(15) == 0);
      nmi   = ($urandom_range(15) == 0);
      intr  = ($urandom_range(15) == 0);
      core_rst = ($urandom_range(39) == 0);
      cfg_we = ($urandom_range(49) == 0);
      cfg_wdata = $urandom;
      cyc();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule